// File: doc/BRIEF.md
# DMA Request Arbiter with Buffered Command Queue

This block places the bus requests of three channel engines, plus slave reads arriving from the system bus, onto one shared system-bus master port. A round-robin arbiter picks one requester at a time. When the winner is an engine, the block captures the transfer header that the engine drives on its data-out word: direction, burst length and address. The engine index is kept as the channel ID. A write burst is first copied beat by beat into one of two burst buffers, and only then is a command posted. A read is posted at once, with no data phase on the internal side.

A master-port sequencer takes commands from a two-entry queue in the order they were accepted. For each command it requests the bus and moves the beats. On a read it forwards the returned beats to the engine that asked for them. When the bus reports a write complete, it returns a done pulse and the error status to the engine that issued the write.

The arbiter is freed as soon as a command is queued, so a second request can be accepted while the first is still waiting for the bus. A write copy locks the internal bus until its last beat is held in a buffer. A granted slave read holds that lock until the slave side reports the read finished. Slave writes never pass through the arbiter: each one goes straight to the engine it selects.

Top module: `dma_arb`

## Requirements
- R1: While reset is asserted, and after it is released with no requests, ce_ack, ce_wgnt, ce_rgnt, ce_done, ce_werr, ce_rvalid, slv_rd_gnt and bus_req are all 0.
- R2: Requesters are indexed 0..2 for the engines and 3 for the slave read. The search starts at the index after the last granted one and wraps around. The starting point moves only when a grant is issued, and it is 0 after reset.
- R3: A write grant raises ce_wgnt of the engine for exactly len+1 cycles and captures one data-out beat per cycle. The posted command then presents rd=0 with the header's address and length, and bus_wdata carries the beats in their original order.
- R4: For a read, ce_rgnt of the issuing engine is 0 until the bus grant has been taken. After that, ce_rvalid and ce_rdata forward each bus beat, and ce_rgnt is high for exactly len+1 beat cycles.
- R5: The cycle after bus_done ends a write, ce_done of the issuing engine pulses for one cycle, and ce_werr of that engine carries bus_err in the same cycle. Other engines see neither signal.
- R6: At most two commands are outstanding. While both queue entries are held, no engine request is acknowledged.
- R7: A request can be acknowledged while an earlier queued command has not yet received the bus.
- R8: While a write copy is in progress, no other requester is granted. A granted slave read keeps slv_rd_gnt high until slv_rd_done, and no engine is acknowledged during that time. A slave read is granted even when the queue is full.
- R9: When slv_wr_stb is high, ce_swr is one-hot at index slv_wr_sel in the same cycle and ce_swr_data equals slv_wr_data. This holds during a write copy as well.
- R10: Commands reach the bus in the order in which their requests were acknowledged.
- R11: The header word uses bit 63 for read (1) or write (0), bits 42:40 for the burst length in 8-byte beats minus one (1 to 8 beats, that is 8 to 64 bytes), and bits 31:0 for the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_req | input | NUM_CE | Bus request per engine |
| ce_dout | input | NUM_CE*DATA_W | Per-engine data-out word: header while requesting, write beats while granted |
| ce_ack | output | NUM_CE | One-cycle pulse: the header has been taken |
| ce_wgnt | output | NUM_CE | Write copy grant; one beat is captured per cycle |
| ce_rgnt | output | NUM_CE | Read data grant while the bus transfer runs |
| ce_rdata | output | DATA_W | Forwarded read beat |
| ce_rvalid | output | 1 | A read beat is valid on ce_rdata |
| ce_done | output | NUM_CE | Write completion pulse |
| ce_werr | output | NUM_CE | Write error status, valid with ce_done |
| slv_rd_req | input | 1 | Slave read request |
| slv_rd_done | input | 1 | Slave read finished; releases the lock |
| slv_rd_gnt | output | 1 | Slave read owns the internal bus |
| slv_wr_stb | input | 1 | Slave write strobe |
| slv_wr_sel | input | 2 | Target engine of the slave write |
| slv_wr_data | input | SLV_W | Slave write data |
| ce_swr | output | NUM_CE | Slave write strobe per engine |
| ce_swr_data | output | SLV_W | Slave write data to the engines |
| bus_req | output | 1 | Master port wants the bus |
| bus_gnt | input | 1 | Bus won, one-cycle pulse |
| bus_rd | output | 1 | Current command is a read |
| bus_addr | output | 32 | Current command address |
| bus_len | output | 3 | Current command beats minus one |
| bus_wdata | output | DATA_W | Write beat for the current cycle |
| bus_beat | input | 1 | One beat moves this cycle |
| bus_rdata | input | DATA_W | Read beat from the bus |
| bus_done | input | 1 | Current command completed |
| bus_err | input | 1 | Error status, valid with bus_done |

## Verification
The hardest condition to reach is a full queue with several requesters still waiting. The bench model of the bus can withhold its grant. With the grant withheld, all three engines request together, so the queue fills, the round-robin order can be observed, and the third engine can be seen to wait. Releasing the bus then shows which requester is served next. Slave reads are driven against a write copy in progress and against a full queue, which shows both that the lock holds and that slave reads do not depend on buffer space. A slave write is driven in the middle of a write copy to show that it bypasses the arbiter.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int ADDR_W      = 32;
  localparam int MAX_BEATS   = 8;
  localparam int LEN_W       = $clog2(MAX_BEATS);
  localparam int ID_W        = 2;
  localparam int HDR_RD_BIT  = 63;
  localparam int HDR_LEN_LSB = 40;

  typedef struct packed {
    logic              rd;
    logic [ID_W-1:0]   id;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  typedef enum logic [1:0] {ARB_IDLE, ARB_WCOPY, ARB_SLVRD} arb_st_e;
  typedef enum logic [1:0] {MP_IDLE, MP_REQ, MP_XFER, MP_WAIT} mp_st_e;
endpackage

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt,
  output logic         any
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q, ptr_n, win;

  always_comb begin
    gnt = '0;
    win = '0;
    any = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!any && req[idx]) begin
        gnt[idx] = 1'b1;
        win      = PW'(idx);
        any      = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_n = ptr_q;
    if (adv && any) ptr_n = (win == PW'(N - 1)) ? '0 : win + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end
endmodule

// File: rtl/dma_cmd_queue.sv
module dma_cmd_queue import dma_arb_pkg::*; #(
  parameter int DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  cmd_t                    push_cmd,
  input  logic                    pop,
  output cmd_t                    head,
  output logic [$clog2(DEPTH)-1:0] wr_idx,
  output logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic                    full,
  output logic                    empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  cmd_t             mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (push) wr_n = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_n = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop) cnt_n = cnt_q + 1'b1;
    if (pop && !push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      if (push) mem_q[wr_q] <= push_cmd;
    end
  end

  assign head   = mem_q[rd_q];
  assign wr_idx = wr_q;
  assign rd_idx = rd_q;
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign empty  = (cnt_q == '0);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/dma_write_buf.sv
module dma_write_buf #(
  parameter int NBUF   = 2,
  parameter int BEATS  = 8,
  parameter int DATA_W = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(NBUF)-1:0]  wslot,
  input  logic [$clog2(BEATS)-1:0] wbeat,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [$clog2(NBUF)-1:0]  rslot,
  input  logic [$clog2(BEATS)-1:0] rbeat,
  output logic [DATA_W-1:0]        rdata
);
  localparam int ENTRIES = NBUF * BEATS;

  logic [DATA_W-1:0] mem_q [ENTRIES];
  int waddr, raddr;

  always_comb begin
    waddr = int'(wslot) * BEATS + int'(wbeat);
    raddr = int'(rslot) * BEATS + int'(rbeat);
  end

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/dma_mport_seq.sv
module dma_mport_seq import dma_arb_pkg::*; #(
  parameter int NUM_CE = 3,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  cmd_t              head,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              pop,
  output logic [LEN_W-1:0]  rbeat,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LEN_W-1:0]  bus_len,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_beat,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done,
  input  logic              bus_err,
  output logic [NUM_CE-1:0] ce_rgnt,
  output logic [DATA_W-1:0] ce_rdata,
  output logic              ce_rvalid,
  output logic [NUM_CE-1:0] ce_done,
  output logic [NUM_CE-1:0] ce_werr
);
  mp_st_e            st_q, st_n;
  logic [LEN_W-1:0]  beat_q, beat_n;
  logic [NUM_CE-1:0] done_q, done_n, werr_q, werr_n;
  logic              in_xfer;

  always_comb begin
    st_n   = st_q;
    beat_n = beat_q;
    done_n = '0;
    werr_n = '0;
    pop    = 1'b0;
    case (st_q)
      MP_IDLE: if (!q_empty) st_n = MP_REQ;
      MP_REQ:  if (bus_gnt) begin
        st_n   = MP_XFER;
        beat_n = '0;
      end
      MP_XFER: if (bus_beat) begin
        if (beat_q == head.len) st_n = MP_WAIT;
        else                    beat_n = beat_q + 1'b1;
      end
      MP_WAIT: if (bus_done) begin
        pop  = 1'b1;
        st_n = MP_IDLE;
        if (!head.rd) begin
          done_n[head.id] = 1'b1;
          werr_n[head.id] = bus_err;
        end
      end
      default: st_n = MP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MP_IDLE;
      beat_q <= '0;
      done_q <= '0;
      werr_q <= '0;
    end else begin
      st_q   <= st_n;
      beat_q <= beat_n;
      done_q <= done_n;
      werr_q <= werr_n;
    end
  end

  assign in_xfer   = (st_q == MP_XFER);
  assign bus_req   = (st_q != MP_IDLE);
  assign bus_rd    = head.rd;
  assign bus_addr  = head.addr;
  assign bus_len   = head.len;
  assign bus_wdata = buf_rdata;
  assign rbeat     = beat_q;
  assign ce_rdata  = bus_rdata;
  assign ce_rvalid = in_xfer && head.rd && bus_beat;
  assign ce_done   = done_q;
  assign ce_werr   = werr_q;

  always_comb begin
    ce_rgnt = '0;
    for (int i = 0; i < NUM_CE; i++)
      if (in_xfer && head.rd && (head.id == ID_W'(i))) ce_rgnt[i] = 1'b1;
  end

  assert_rgnt_after_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|ce_rgnt) |-> $past(bus_gnt));
  assert_done_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ce_done));
  assert_done_follows_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ce_done) |-> $past(bus_done));
endmodule

// File: rtl/dma_arb.sv
module dma_arb import dma_arb_pkg::*; #(
  parameter int NUM_CE = 3,
  parameter int DATA_W = 64,
  parameter int SLV_W  = 32,
  parameter int QDEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CE-1:0]        ce_req,
  input  logic [NUM_CE*DATA_W-1:0] ce_dout,
  output logic [NUM_CE-1:0]        ce_ack,
  output logic [NUM_CE-1:0]        ce_wgnt,
  output logic [NUM_CE-1:0]        ce_rgnt,
  output logic [DATA_W-1:0]        ce_rdata,
  output logic                     ce_rvalid,
  output logic [NUM_CE-1:0]        ce_done,
  output logic [NUM_CE-1:0]        ce_werr,
  input  logic                     slv_rd_req,
  input  logic                     slv_rd_done,
  output logic                     slv_rd_gnt,
  input  logic                     slv_wr_stb,
  input  logic [ID_W-1:0]          slv_wr_sel,
  input  logic [SLV_W-1:0]         slv_wr_data,
  output logic [NUM_CE-1:0]        ce_swr,
  output logic [SLV_W-1:0]         ce_swr_data,
  output logic                     bus_req,
  input  logic                     bus_gnt,
  output logic                     bus_rd,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [LEN_W-1:0]         bus_len,
  output logic [DATA_W-1:0]        bus_wdata,
  input  logic                     bus_beat,
  input  logic [DATA_W-1:0]        bus_rdata,
  input  logic                     bus_done,
  input  logic                     bus_err
);
  localparam int NREQ   = NUM_CE + 1;
  localparam int SLV_IX = NUM_CE;
  localparam int QW     = $clog2(QDEPTH);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  arb_st_e           st_q, st_n;
  cmd_t              hdr_q, hdr_n, push_cmd, win_cmd;
  logic [LEN_W-1:0]  beat_q, beat_n;
  logic [NUM_CE-1:0] wgnt_q, wgnt_n, ack_q, ack_n;
  logic              slvg_q, slvg_n;
  logic [NREQ-1:0]   rr_req, rr_gnt;
  logic              rr_any, rr_adv, push;
  logic              q_full, q_empty, q_pop;
  cmd_t              q_head;
  logic [QW-1:0]     q_wr_idx, q_rd_idx;
  logic [DATA_W-1:0] win_dout, copy_dout, buf_rdata;
  logic [LEN_W-1:0]  seq_rbeat;
  logic              buf_we;

  assign rr_req = {slv_rd_req, ce_req & {NUM_CE{!q_full}}};
  assign rr_adv = (st_q == ARB_IDLE) && rr_any;

  dma_rr_arb #(.N(NREQ)) i_rr (
    .clk(clk), .rst_n(rst_i_n), .req(rr_req), .adv(rr_adv),
    .gnt(rr_gnt), .any(rr_any)
  );

  // header of the current winner, and the data-out word of the engine being copied
  always_comb begin
    win_dout = '0;
    win_cmd  = '0;
    for (int i = 0; i < NUM_CE; i++) begin
      if (rr_gnt[i]) begin
        win_dout   = ce_dout[i*DATA_W +: DATA_W];
        win_cmd.id = ID_W'(i);
      end
    end
    win_cmd.rd   = win_dout[HDR_RD_BIT];
    win_cmd.len  = win_dout[HDR_LEN_LSB +: LEN_W];
    win_cmd.addr = win_dout[ADDR_W-1:0];
    copy_dout    = ce_dout[int'(hdr_q.id)*DATA_W +: DATA_W];
  end

  always_comb begin
    st_n     = st_q;
    hdr_n    = hdr_q;
    beat_n   = beat_q;
    wgnt_n   = wgnt_q;
    slvg_n   = slvg_q;
    ack_n    = '0;
    push     = 1'b0;
    push_cmd = win_cmd;
    buf_we   = 1'b0;
    case (st_q)
      ARB_IDLE: if (rr_any) begin
        if (rr_gnt[SLV_IX]) begin
          slvg_n = 1'b1;
          st_n   = ARB_SLVRD;
        end else begin
          ack_n = rr_gnt[NUM_CE-1:0];
          if (win_cmd.rd) begin
            push = 1'b1;
          end else begin
            hdr_n  = win_cmd;
            beat_n = '0;
            wgnt_n = rr_gnt[NUM_CE-1:0];
            st_n   = ARB_WCOPY;
          end
        end
      end
      ARB_WCOPY: begin
        buf_we = 1'b1;
        if (beat_q == hdr_q.len) begin
          push     = 1'b1;
          push_cmd = hdr_q;
          wgnt_n   = '0;
          st_n     = ARB_IDLE;
        end else begin
          beat_n = beat_q + 1'b1;
        end
      end
      ARB_SLVRD: if (slv_rd_done) begin
        slvg_n = 1'b0;
        st_n   = ARB_IDLE;
      end
      default: st_n = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ARB_IDLE;
      hdr_q  <= '0;
      beat_q <= '0;
      wgnt_q <= '0;
      ack_q  <= '0;
      slvg_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      hdr_q  <= hdr_n;
      beat_q <= beat_n;
      wgnt_q <= wgnt_n;
      ack_q  <= ack_n;
      slvg_q <= slvg_n;
    end
  end

  dma_cmd_queue #(.DEPTH(QDEPTH)) i_q (
    .clk(clk), .rst_n(rst_i_n), .push(push), .push_cmd(push_cmd), .pop(q_pop),
    .head(q_head), .wr_idx(q_wr_idx), .rd_idx(q_rd_idx), .full(q_full), .empty(q_empty)
  );

  dma_write_buf #(.NBUF(QDEPTH), .BEATS(MAX_BEATS), .DATA_W(DATA_W)) i_buf (
    .clk(clk), .we(buf_we), .wslot(q_wr_idx), .wbeat(beat_q), .wdata(copy_dout),
    .rslot(q_rd_idx), .rbeat(seq_rbeat), .rdata(buf_rdata)
  );

  dma_mport_seq #(.NUM_CE(NUM_CE), .DATA_W(DATA_W)) i_seq (
    .clk(clk), .rst_n(rst_i_n), .q_empty(q_empty), .head(q_head), .buf_rdata(buf_rdata),
    .pop(q_pop), .rbeat(seq_rbeat), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
    .bus_beat(bus_beat), .bus_rdata(bus_rdata), .bus_done(bus_done), .bus_err(bus_err),
    .ce_rgnt(ce_rgnt), .ce_rdata(ce_rdata), .ce_rvalid(ce_rvalid),
    .ce_done(ce_done), .ce_werr(ce_werr)
  );

  // slave writes go straight to the selected engine
  always_comb begin
    ce_swr = '0;
    for (int i = 0; i < NUM_CE; i++)
      if (slv_wr_stb && (slv_wr_sel == ID_W'(i))) ce_swr[i] = 1'b1;
  end
  assign ce_swr_data = slv_wr_data;

  assign ce_ack     = ack_q;
  assign ce_wgnt    = wgnt_q;
  assign slv_rd_gnt = slvg_q;

  assert_ack_onehot_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(ce_ack));
  assert_full_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    q_full |=> (ce_ack == '0));
  assert_copy_lock_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|ce_wgnt) |-> !slv_rd_gnt);
  assert_slave_lock_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (slv_rd_gnt && $past(slv_rd_gnt)) |-> (ce_ack == '0));
  assert_swr_idle_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !slv_wr_stb |-> (ce_swr == '0));
endmodule

// File: tb/test_dma_arb.sv
`timescale 1ns/1ps
module test_dma_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]   ce_req = '0;
  logic [191:0] ce_dout = '0;
  logic [2:0]   ce_ack, ce_wgnt, ce_rgnt, ce_done, ce_werr, ce_swr;
  logic [63:0]  ce_rdata, bus_wdata;
  logic         ce_rvalid, slv_rd_gnt, bus_req, bus_rd;
  logic         slv_rd_req = 0, slv_rd_done = 0, slv_wr_stb = 0;
  logic [1:0]   slv_wr_sel = 0;
  logic [31:0]  slv_wr_data = 0, ce_swr_data, bus_addr;
  logic [2:0]   bus_len;
  logic         bus_gnt = 0, bus_beat = 0, bus_done = 0, bus_err = 0;
  logic [63:0]  bus_rdata = '0;

  dma_arb i_dma_arb (
    .clk(clk), .rst_n(rst_n), .ce_req(ce_req), .ce_dout(ce_dout), .ce_ack(ce_ack),
    .ce_wgnt(ce_wgnt), .ce_rgnt(ce_rgnt), .ce_rdata(ce_rdata), .ce_rvalid(ce_rvalid),
    .ce_done(ce_done), .ce_werr(ce_werr), .slv_rd_req(slv_rd_req),
    .slv_rd_done(slv_rd_done), .slv_rd_gnt(slv_rd_gnt), .slv_wr_stb(slv_wr_stb),
    .slv_wr_sel(slv_wr_sel), .slv_wr_data(slv_wr_data), .ce_swr(ce_swr),
    .ce_swr_data(ce_swr_data), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata), .bus_beat(bus_beat),
    .bus_rdata(bus_rdata), .bus_done(bus_done), .bus_err(bus_err)
  );

  int checks = 0, errors = 0, cyc = 0;
  int n_ack, n_done, n_rd, n_cmd, rgnt_early;
  int ack_log [32];
  logic [2:0] done_log [32], werr_log [32];
  logic [63:0] rd_cap [64];
  logic cmd_rd [32];
  logic [31:0] cmd_addr [32];
  logic [2:0] cmd_len [32];
  logic [63:0] wcap [32][8];
  int wgnt_cyc [3], rgnt_cyc [3];
  logic bus_hold = 0, err_next = 0;

  function automatic logic [63:0] hdr(logic rd, logic [2:0] len, logic [31:0] addr);
    return {rd, 20'h0, len, 8'h0, addr};
  endfunction
  function automatic logic [63:0] wpat(int id, int k);
    return 64'hA5A5_0000_0000_0000 | (64'(id) << 16) | 64'(k * 7 + 1);
  endfunction
  function automatic logic [63:0] rpat(int k);
    return 64'h5A00_0000_0000_0000 + 64'(k * 3 + 11);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_ack = 0; n_done = 0; n_rd = 0; n_cmd = 0; rgnt_early = 0;
    for (int i = 0; i < 3; i++) begin wgnt_cyc[i] = 0; rgnt_cyc[i] = 0; end
  endtask

  // monitor, samples 1 ns after the falling edge
  initial begin
    clear_logs();
    forever begin
      @(negedge clk); #1;
      cyc++;
      for (int i = 0; i < 3; i++) begin
        if (ce_wgnt[i]) wgnt_cyc[i]++;
        if (ce_rgnt[i]) rgnt_cyc[i]++;
        if (ce_ack[i]) begin ack_log[n_ack] = i; n_ack++; end
      end
      if (|ce_done) begin done_log[n_done] = ce_done; werr_log[n_done] = ce_werr; n_done++; end
      if (ce_rvalid) begin rd_cap[n_rd] = ce_rdata; n_rd++; end
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  // bus model
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req && !bus_hold) begin
        logic rd_l; logic [2:0] len_l; int n;
        @(negedge clk);
        if (ce_rgnt != 0) rgnt_early++;
        n = n_cmd;
        rd_l = bus_rd; len_l = bus_len;
        cmd_rd[n] = bus_rd; cmd_addr[n] = bus_addr; cmd_len[n] = bus_len;
        bus_gnt = 1;
        @(negedge clk);
        bus_gnt = 0;
        for (int k = 0; k <= int'(len_l); k++) begin
          bus_beat = 1; bus_rdata = rpat(k);
          if (!rd_l) wcap[n][k] = bus_wdata;
          @(negedge clk);
        end
        bus_beat = 0; bus_done = 1; bus_err = err_next;
        @(negedge clk);
        bus_done = 0; bus_err = 0; err_next = 0;
        n_cmd++;
      end
    end
  end

  task automatic eng_write(int id, logic [31:0] addr, logic [2:0] len);
    int k = 0;
    ce_dout[id*64 +: 64] = hdr(1'b0, len, addr);
    ce_req[id] = 1'b1;
    while (!ce_wgnt[id]) @(negedge clk);
    ce_req[id] = 1'b0;
    while (ce_wgnt[id]) begin
      ce_dout[id*64 +: 64] = wpat(id, k); k++;
      @(negedge clk);
    end
  endtask

  task automatic eng_read(int id, logic [31:0] addr, logic [2:0] len);
    ce_dout[id*64 +: 64] = hdr(1'b1, len, addr);
    ce_req[id] = 1'b1;
    @(negedge clk);
    while (!ce_ack[id]) @(negedge clk);
    ce_req[id] = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk);
      if (bus_req || bus_gnt || bus_done || (|ce_wgnt)) quiet = 0; else quiet++;
    end
  endtask

  task automatic t_reset();
    #1;
    chk(ce_ack == 0 && ce_wgnt == 0 && ce_done == 0 && !slv_rd_gnt && !bus_req,
        "R1", "outputs in reset", {ce_ack, ce_wgnt, ce_done, slv_rd_gnt, bus_req}, 0);
    @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);
    chk(ce_ack == 0 && ce_wgnt == 0 && ce_rgnt == 0 && ce_werr == 0 && !ce_rvalid &&
        !slv_rd_gnt && !bus_req, "R1", "outputs after reset",
        {ce_ack, ce_wgnt, ce_rgnt, ce_werr, ce_rvalid, slv_rd_gnt, bus_req}, 0);
  endtask

  task automatic t_write_ok();
    clear_logs();
    eng_write(0, 32'h0000_1000, 3'd3);
    wait_idle();
    chk(wgnt_cyc[0] == 4, "R3", "write grant cycles", wgnt_cyc[0], 4);
    chk(n_cmd == 1 && cmd_rd[0] == 0 && cmd_addr[0] == 32'h1000 && cmd_len[0] == 3,
        "R11", "write command fields", {cmd_rd[0], cmd_len[0], cmd_addr[0]}, {1'b0, 3'd3, 32'h1000});
    for (int k = 0; k < 4; k++)
      chk(wcap[0][k] == wpat(0, k), "R3", "write beat order", wcap[0][k], wpat(0, k));
    chk(n_done == 1 && done_log[0] == 3'b001 && werr_log[0] == 3'b000, "R5",
        "write done ok", {done_log[0], werr_log[0]}, {3'b001, 3'b000});
  endtask

  task automatic t_write_err();
    clear_logs();
    err_next = 1;
    eng_write(2, 32'h0000_2200, 3'd1);
    wait_idle();
    chk(wgnt_cyc[2] == 2, "R3", "two-beat grant", wgnt_cyc[2], 2);
    chk(n_done == 1 && done_log[0] == 3'b100 && werr_log[0] == 3'b100, "R5",
        "write error routed", {done_log[0], werr_log[0]}, {3'b100, 3'b100});
  endtask

  task automatic t_read();
    clear_logs();
    eng_read(1, 32'h0000_3300, 3'd7);
    wait_idle();
    chk(n_cmd == 1 && cmd_rd[0] == 1 && cmd_len[0] == 7 && cmd_addr[0] == 32'h3300, "R11",
        "read command fields", {cmd_rd[0], cmd_len[0], cmd_addr[0]}, {1'b1, 3'd7, 32'h3300});
    chk(rgnt_early == 0, "R4", "read grant before bus", rgnt_early, 0);
    chk(rgnt_cyc[1] == 8 && rgnt_cyc[0] == 0 && rgnt_cyc[2] == 0, "R4", "read grant cycles",
        rgnt_cyc[1], 8);
    chk(n_rd == 8, "R4", "read beats forwarded", n_rd, 8);
    for (int k = 0; k < 8; k++)
      chk(rd_cap[k] == rpat(k), "R4", "read data", rd_cap[k], rpat(k));
    chk(n_done == 0, "R5", "no done for read", n_done, 0);
  endtask

  // last grant was engine 1, so the search starts at 2
  task automatic t_round_robin_full();
    int ack_at_second;
    clear_logs();
    bus_hold = 1;
    fork
      eng_read(0, 32'h0000_4000, 3'd0);
      eng_read(1, 32'h0000_4100, 3'd0);
      eng_read(2, 32'h0000_4200, 3'd0);
      begin
        while (n_ack < 2) @(negedge clk);
        ack_at_second = n_cmd;
        repeat (20) @(negedge clk);
        chk(n_ack == 2, "R6", "third request held while full", n_ack, 2);
        chk(ack_at_second == 0, "R7", "second ack before any bus grant", ack_at_second, 0);
        bus_hold = 0;
      end
    join
    wait_idle();
    chk(n_ack == 3 && ack_log[0] == 2 && ack_log[1] == 0 && ack_log[2] == 1, "R2",
        "round-robin order", {ack_log[0][3:0], ack_log[1][3:0], ack_log[2][3:0]}, 12'h201);
    chk(n_cmd == 3 && cmd_addr[0] == 32'h4200 && cmd_addr[1] == 32'h4000 &&
        cmd_addr[2] == 32'h4100, "R10", "bus command order",
        {cmd_addr[0][11:8], cmd_addr[1][11:8], cmd_addr[2][11:8]}, 12'h201);
  endtask

  // last grant was engine 1: slave (index 3) wins over engine 0
  task automatic t_slave_first();
    clear_logs();
    fork
      eng_write(0, 32'h0000_5000, 3'd1);
      begin
        slv_rd_req = 1;
        @(negedge clk);
        while (!slv_rd_gnt) @(negedge clk);
        chk(n_ack == 0, "R2", "slave read wins rotation", n_ack, 0);
        repeat (6) @(negedge clk);
        chk(slv_rd_gnt == 1 && n_ack == 0, "R8", "slave lock held", {slv_rd_gnt, n_ack[3:0]}, 5'h10);
        slv_rd_done = 1; slv_rd_req = 0;
        @(negedge clk);
        slv_rd_done = 0;
      end
    join
    wait_idle();
    chk(!slv_rd_gnt && n_ack == 1 && ack_log[0] == 0, "R8", "engine served after slave",
        {slv_rd_gnt, n_ack[3:0]}, 5'h01);
  endtask

  task automatic t_copy_lock();
    clear_logs();
    fork
      eng_write(1, 32'h0000_6000, 3'd7);
      begin
        while (!ce_wgnt[1]) @(negedge clk);
        @(negedge clk);
        slv_rd_req = 1;
        slv_wr_stb = 1; slv_wr_sel = 2; slv_wr_data = 32'hC0DE_0042;
        #1;
        chk(ce_swr == 3'b100 && ce_swr_data == 32'hC0DE_0042, "R9", "slave write bypass",
            {ce_swr, ce_swr_data}, {3'b100, 32'hC0DE_0042});
        @(negedge clk);
        slv_wr_stb = 0;
        while (!slv_rd_gnt) @(negedge clk);
        chk(wgnt_cyc[1] == 8, "R8", "slave waits for write copy", wgnt_cyc[1], 8);
        repeat (2) @(negedge clk);
        slv_rd_done = 1; slv_rd_req = 0;
        @(negedge clk);
        slv_rd_done = 0;
      end
    join
    wait_idle();
    chk(wcap[0][7] == wpat(1, 7), "R3", "last beat of long burst", wcap[0][7], wpat(1, 7));
  endtask

  task automatic t_slave_when_full();
    clear_logs();
    bus_hold = 1;
    fork
      eng_read(0, 32'h0000_7000, 3'd1);
      eng_read(2, 32'h0000_7200, 3'd1);
    join
    slv_rd_req = 1;
    repeat (4) @(negedge clk);
    chk(slv_rd_gnt == 1, "R8", "slave read granted with queue full", slv_rd_gnt, 1);
    slv_rd_done = 1; slv_rd_req = 0;
    @(negedge clk);
    slv_rd_done = 0;
    bus_hold = 0;
    wait_idle();
    chk(n_rd == 4 && n_cmd == 2, "R6", "both queued reads completed", n_rd, 4);
  endtask

  initial begin
    t_reset();
    t_write_ok();
    t_write_err();
    t_read();
    t_round_robin_full();
    t_slave_first();
    t_copy_lock();
    t_slave_when_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule